// File: doc/BRIEF.md
# Register-Register Integer Execute Unit

This unit executes one register-to-register integer instruction per clock. A 32-bit instruction word comes in with a valid strobe. The unit decodes it and reads two operands from an internal bank of 32 general registers, each XLEN bits wide. It computes one of ten arithmetic, comparison, logic or shift results and writes that value back to the destination register. The same result also appears on a registered writeback port one cycle later.

Encodings that the unit does not recognise raise an illegal-instruction pulse and leave every register untouched. A test port can read any register combinationally and can load a register at a clock edge. A bench or bring-up harness uses it to seed operands and to inspect results. A mode input requests data-independent timing. Every operation already uses the same single-cycle path, so the timing is identical for all operand values whether or not the mode is set.

Top module: `rr_exec_unit`

## Requirements
- R1: Bits [6:0] must equal 0110011 for an instruction to be accepted. The first source index is taken from bits [19:15], the second from bits [24:20] and the destination from bits [11:7].
- R2: The operation is selected by {funct7 = bits [31:25], funct3 = bits [14:12]}: add 0000000/000, sub 0100000/000, sll 0000000/001, slt 0000000/010, sltu 0000000/011, xor 0000000/100, srl 0000000/101, sra 0100000/101, or 0000000/110, and 0000000/111.
- R3: Add and subtract wrap modulo 2^XLEN and give no overflow indication.
- R4: Signed set-less-than compares the operands as two's-complement values. Unsigned set-less-than compares them as unsigned values. Each gives 1 or 0, zero-extended to XLEN.
- R5: AND, OR and XOR are bitwise over all XLEN bits.
- R6: Shifts use only the low 5 bits of the second operand when XLEN is 32, or the low 6 bits when XLEN is 64. The arithmetic right shift fills vacated bits with the sign bit of the first operand; the logical shifts fill them with zeros.
- R7: For any other opcode or funct combination, illegal_op is high for exactly the cycle after the valid input, wb_done stays low, and no register changes.
- R8: Register 0 always reads as zero. Writes aimed at it, from an instruction or from the test port, are discarded.
- R9: For every accepted instruction, wb_done, wb_dest and wb_value are valid exactly one cycle after the valid input. This latency is the same for all operations and operand values, with the timing-mode input either high or low.
- R10: The test port read data reflects the addressed register combinationally. A test write stores its data at the clock edge. When an instruction writes the same register in that cycle, the instruction result wins.
- R11: After reset, wb_done and illegal_op are low and all registers read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Instruction word is present this cycle |
| instr_word | input | 32 | Instruction encoding |
| const_time_en | input | 1 | Request for data-independent timing |
| tp_addr | input | 5 | Test port register index |
| tp_we | input | 1 | Test port write enable |
| tp_wdata | input | XLEN | Test port write data |
| tp_rdata | output | XLEN | Test port read data |
| wb_done | output | 1 | Writeback strobe, one cycle after an accepted instruction |
| wb_dest | output | 5 | Destination index of the writeback |
| wb_value | output | XLEN | Result of the writeback |
| illegal_op | output | 1 | Pulse for an unrecognised encoding |

## Verification
An instruction writeback and a test-port write can target the same register on the same clock edge. The bench provokes this by raising the test write in the same cycle as a valid instruction, with the test address equal to the destination field. It then reads the register back through the test port and expects the instruction result rather than the test data. A second overlap is a dependent instruction issued right after its producer, whose operand read in one cycle must see the value written at the edge just before it. The bench issues such pairs back to back and compares both writebacks against its own model.

// File: rtl/rr_exec_pkg.sv
package rr_exec_pkg;

  typedef enum logic [3:0] {
    OP_ADD, OP_SUB, OP_SLL, OP_SLT, OP_SLTU,
    OP_XOR, OP_SRL, OP_SRA, OP_OR, OP_AND
  } alu_op_e;

  localparam logic [6:0] OPC_REG_REG = 7'b0110011;
  localparam int unsigned REG_IDX_W  = 5;

  typedef struct packed {
    logic                   legal;
    alu_op_e                op;
    logic [REG_IDX_W-1:0]   src_a;
    logic [REG_IDX_W-1:0]   src_b;
    logic [REG_IDX_W-1:0]   dst;
  } dec_t;

endpackage

// File: rtl/rr_decoder.sv
module rr_decoder
  import rr_exec_pkg::*;
(
  input  logic [31:0] instr,
  output dec_t        dec
);

  logic [6:0] opcode;
  logic [2:0] f3;
  logic [6:0] f7;
  logic       fn_ok;
  alu_op_e    op_sel;

  assign opcode = instr[6:0];
  assign f3     = instr[14:12];
  assign f7     = instr[31:25];

  // R2: operation table
  always_comb begin
    fn_ok  = 1'b1;
    op_sel = OP_ADD;
    unique case ({f7, f3})
      {7'b0000000, 3'b000}: op_sel = OP_ADD;
      {7'b0100000, 3'b000}: op_sel = OP_SUB;
      {7'b0000000, 3'b001}: op_sel = OP_SLL;
      {7'b0000000, 3'b010}: op_sel = OP_SLT;
      {7'b0000000, 3'b011}: op_sel = OP_SLTU;
      {7'b0000000, 3'b100}: op_sel = OP_XOR;
      {7'b0000000, 3'b101}: op_sel = OP_SRL;
      {7'b0100000, 3'b101}: op_sel = OP_SRA;
      {7'b0000000, 3'b110}: op_sel = OP_OR;
      {7'b0000000, 3'b111}: op_sel = OP_AND;
      default:              fn_ok  = 1'b0;
    endcase
  end

  // R1: field positions
  always_comb begin
    dec.legal = fn_ok && (opcode == OPC_REG_REG);
    dec.op    = op_sel;
    dec.src_a = instr[19:15];
    dec.src_b = instr[24:20];
    dec.dst   = instr[11:7];
  end

endmodule

// File: rtl/rr_alu.sv
module rr_alu
  import rr_exec_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  alu_op_e           op,
  input  logic [XLEN-1:0]   opnd_a,
  input  logic [XLEN-1:0]   opnd_b,
  output logic [XLEN-1:0]   result
);

  localparam int unsigned SHW = (XLEN == 64) ? 6 : 5;

  logic [SHW-1:0] shamt;
  logic           lt_signed;
  logic           lt_unsigned;

  // R6: the amount width follows XLEN
  generate
    if (XLEN == 64) begin : g_sh64
      assign shamt = opnd_b[5:0];
    end else begin : g_sh32
      assign shamt = opnd_b[4:0];
    end
  endgenerate

  function automatic logic [XLEN-1:0] f_zext1(input logic bit_in);
    return {{(XLEN-1){1'b0}}, bit_in};
  endfunction

  function automatic logic f_lt_s(input logic [XLEN-1:0] a, input logic [XLEN-1:0] b);
    return $signed(a) < $signed(b);
  endfunction

  function automatic logic f_lt_u(input logic [XLEN-1:0] a, input logic [XLEN-1:0] b);
    return a < b;
  endfunction

  function automatic logic [XLEN-1:0] f_sra(input logic [XLEN-1:0] a, input logic [SHW-1:0] s);
    return $unsigned($signed(a) >>> s);
  endfunction

  assign lt_signed   = f_lt_s(opnd_a, opnd_b);
  assign lt_unsigned = f_lt_u(opnd_a, opnd_b);

  always_comb begin
    unique case (op)
      OP_ADD:  result = opnd_a + opnd_b;
      OP_SUB:  result = opnd_a - opnd_b;
      OP_SLL:  result = opnd_a << shamt;
      OP_SLT:  result = f_zext1(lt_signed);
      OP_SLTU: result = f_zext1(lt_unsigned);
      OP_XOR:  result = opnd_a ^ opnd_b;
      OP_SRL:  result = opnd_a >> shamt;
      OP_SRA:  result = f_sra(opnd_a, shamt);
      OP_OR:   result = opnd_a | opnd_b;
      OP_AND:  result = opnd_a & opnd_b;
      default: result = '0;
    endcase
  end

  // R4: comparisons never set any bit above bit 0
  always_comb begin
    if (op == OP_SLT || op == OP_SLTU)
      assert_cmp_zext_R4: assert (result[XLEN-1:1] == '0);
  end

endmodule

// File: rtl/rr_regfile.sv
module rr_regfile #(
  parameter int unsigned XLEN = 32,
  parameter int unsigned NREG = 32,
  localparam int unsigned AW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   rd_a_addr,
  output logic [XLEN-1:0] rd_a_data,
  input  logic [AW-1:0]   rd_b_addr,
  output logic [XLEN-1:0] rd_b_data,
  input  logic [AW-1:0]   tp_addr,
  output logic [XLEN-1:0] tp_rdata,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [XLEN-1:0] wr_data,
  input  logic            tp_we,
  input  logic [XLEN-1:0] tp_wdata
);

  logic [XLEN-1:0] regs [NREG];
  logic            collide;

  // R8, R10: register 0 is never written; the instruction beats the test port
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else begin
      for (int i = 1; i < NREG; i++) begin
        if (wr_en && wr_addr == AW'(i))
          regs[i] <= wr_data;
        else if (tp_we && tp_addr == AW'(i))
          regs[i] <= tp_wdata;
      end
    end
  end

  assign rd_a_data = (rd_a_addr == '0) ? '0 : regs[rd_a_addr];
  assign rd_b_data = (rd_b_addr == '0) ? '0 : regs[rd_b_addr];
  assign tp_rdata  = (tp_addr   == '0) ? '0 : regs[tp_addr];

  assign collide = wr_en && tp_we && (wr_addr == tp_addr) && (wr_addr != '0);

  assert_wb_priority_R10: assert property (@(posedge clk) disable iff (!rst_n)
    collide |=> regs[$past(wr_addr)] == $past(wr_data));

  assert_zero_reg_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en || tp_we) |=> regs[0] == '0);

endmodule

// File: rtl/rr_exec_unit.sv
module rr_exec_unit
  import rr_exec_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            instr_valid,
  input  logic [31:0]     instr_word,
  input  logic            const_time_en,
  input  logic [4:0]      tp_addr,
  input  logic            tp_we,
  input  logic [XLEN-1:0] tp_wdata,
  output logic [XLEN-1:0] tp_rdata,
  output logic            wb_done,
  output logic [4:0]      wb_dest,
  output logic [XLEN-1:0] wb_value,
  output logic            illegal_op
);

  localparam int unsigned NREG = 32;

  dec_t            dec;
  logic [XLEN-1:0] opnd_a;
  logic [XLEN-1:0] opnd_b;
  logic [XLEN-1:0] alu_res;
  logic            accept;
  logic            reject;

  rr_decoder u_dec (
    .instr (instr_word),
    .dec   (dec)
  );

  rr_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_a_addr (dec.src_a),
    .rd_a_data (opnd_a),
    .rd_b_addr (dec.src_b),
    .rd_b_data (opnd_b),
    .tp_addr   (tp_addr),
    .tp_rdata  (tp_rdata),
    .wr_en     (accept),
    .wr_addr   (dec.dst),
    .wr_data   (alu_res),
    .tp_we     (tp_we),
    .tp_wdata  (tp_wdata)
  );

  rr_alu #(.XLEN(XLEN)) u_alu (
    .op     (dec.op),
    .opnd_a (opnd_a),
    .opnd_b (opnd_b),
    .result (alu_res)
  );

  assign accept = instr_valid &&  dec.legal;
  assign reject = instr_valid && !dec.legal;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_done    <= 1'b0;
      wb_dest    <= '0;
      wb_value   <= '0;
      illegal_op <= 1'b0;
    end else begin
      wb_done    <= accept;
      illegal_op <= reject;
      if (accept) begin
        wb_dest  <= dec.dst;
        wb_value <= alu_res;
      end
    end
  end

  assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (wb_done && wb_dest == $past(instr_word[11:7])));

  assert_const_time_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && const_time_en) |=> wb_done);

  assert_illegal_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> (illegal_op && !wb_done));

  assert_accept_opcode_R1: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> instr_word[6:0] == OPC_REG_REG);

  assert_done_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wb_done) |-> $past(instr_valid));

endmodule

// File: tb/test_rr_exec_unit.sv
module test_rr_exec_unit;

  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         instr_valid;
  logic [31:0]  instr_word;
  logic         const_time_en;
  logic [4:0]   tp_addr;
  logic         tp_we;
  logic [W-1:0] tp_wdata;
  logic [W-1:0] tp_rdata;
  logic         wb_done;
  logic [4:0]   wb_dest;
  logic [W-1:0] wb_value;
  logic         illegal_op;

  always #5 clk = ~clk;

  rr_exec_unit #(.XLEN(W)) i_rr_exec_unit (
    .clk, .rst_n, .instr_valid, .instr_word, .const_time_en,
    .tp_addr, .tp_we, .tp_wdata, .tp_rdata,
    .wb_done, .wb_dest, .wb_value, .illegal_op
  );

  int total = 0;
  int bad   = 0;
  bit finished = 0;
  logic [W-1:0] model [32];

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] enc(input logic [6:0] f7, input logic [4:0] b,
                                      input logic [4:0] a, input logic [2:0] f3,
                                      input logic [4:0] d);
    return {f7, b, a, f3, d, 7'b0110011};
  endfunction

  // reference arithmetic written independently
  function automatic logic [W-1:0] ref_calc(input logic [6:0] f7, input logic [2:0] f3,
                                            input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W:0] diff;
    logic [W-1:0] fill;
    int s;
    s = int'(b % W);
    diff = {1'b0, a} + {1'b0, ~b} + 1'b1;
    fill = a[W-1] ? ~({W{1'b1}} >> s) : '0;
    case (f3)
      3'b000: return (f7[5]) ? diff[W-1:0] : a + b;
      3'b001: return a << s;
      3'b010: return ({~a[W-1], a[W-2:0]} < {~b[W-1], b[W-2:0]}) ? 1 : 0;
      3'b011: return diff[W] ? 0 : 1;
      3'b100: return a ^ b;
      3'b101: return (a >> s) | (f7[5] ? fill : '0);
      3'b110: return a | b;
      default: return a & b;
    endcase
  endfunction

  task automatic tp_read_chk(input string req, input logic [4:0] r);
    tp_addr = r;
    #1;
    chk(req, tp_rdata, (r == 0) ? '0 : model[r]);
  endtask

  task automatic tp_write(input logic [4:0] r, input logic [W-1:0] v);
    tp_addr = r; tp_wdata = v; tp_we = 1'b1;
    @(posedge clk); #1;
    tp_we = 1'b0;
    if (r != 0) model[r] = v;
    @(negedge clk);
  endtask

  // issue one instruction at a negedge and check the writeback one cycle on
  task automatic issue(input string req, input logic [31:0] iw, input bit legal);
    logic [W-1:0] exp;
    logic [4:0] d;
    d = iw[11:7];
    exp = ref_calc(iw[31:25], iw[14:12], model[iw[19:15]], model[iw[24:20]]);
    instr_word = iw; instr_valid = 1'b1;
    @(posedge clk); #1;
    instr_valid = 1'b0;
    @(negedge clk);
    if (legal) begin
      chk({req, " done"}, {31'b0, wb_done}, 1);
      chk({req, " dest R1"}, {27'b0, wb_dest}, {27'b0, d});
      chk({req, " value"}, wb_value, exp);
      if (d != 0) model[d] = exp;
      tp_read_chk({req, " regfile"}, d);
    end else begin
      chk({req, " illegal R7"}, {31'b0, illegal_op}, 1);
      chk({req, " no done R7"}, {31'b0, wb_done}, 0);
      tp_read_chk("R7 reg unchanged", d);
    end
    @(negedge clk);
    chk({req, " pulse one cycle R7"}, {31'b0, illegal_op}, 0);
  endtask

  localparam logic [9:0] OPS [10] = '{
    {7'b0000000, 3'b000}, {7'b0100000, 3'b000}, {7'b0000000, 3'b001},
    {7'b0000000, 3'b010}, {7'b0000000, 3'b011}, {7'b0000000, 3'b100},
    {7'b0000000, 3'b101}, {7'b0100000, 3'b101}, {7'b0000000, 3'b110},
    {7'b0000000, 3'b111}};

  initial begin
    #2_000_000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] iw, iw2;
    logic [W-1:0] e1, e2;
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; instr_valid = 1'b0; instr_word = '0; const_time_en = 1'b0;
    tp_addr = '0; tp_we = 1'b0; tp_wdata = '0;
    for (int i = 0; i < 32; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 wb_done", {31'b0, wb_done}, 0);
    chk("R11 illegal_op", {31'b0, illegal_op}, 0);
    tp_read_chk("R11 reg zero", 5'd17);
    rst_n = 1'b1;
    @(negedge clk);

    // R8, R10: seed registers, try to write x0
    tp_write(5'd0, 32'hDEAD_BEEF);
    tp_read_chk("R8 x0 test write", 5'd0);
    tp_write(5'd1, 32'h0000_0000);
    tp_write(5'd2, 32'hFFFF_FFFF);
    tp_write(5'd3, 32'h8000_0000);
    tp_write(5'd4, 32'h7FFF_FFFF);
    tp_write(5'd5, 32'hFFFF_FFE1);  // low five bits = 1
    tp_write(5'd6, 32'hF000_0001);
    for (int r = 7; r < 32; r++) tp_write(5'(r), $urandom());
    tp_read_chk("R10 test read", 5'd6);

    // directed corner cases
    issue("R3 add wrap",   enc(7'b0000000, 5'd2, 5'd2, 3'b000, 5'd10), 1);
    issue("R3 sub wrap",   enc(7'b0100000, 5'd2, 5'd1, 3'b000, 5'd11), 1);
    issue("R4 sltu 0<max", enc(7'b0000000, 5'd2, 5'd1, 3'b011, 5'd12), 1);
    issue("R4 sltu max<0", enc(7'b0000000, 5'd1, 5'd2, 3'b011, 5'd13), 1);
    issue("R4 slt min<max",enc(7'b0000000, 5'd4, 5'd3, 3'b010, 5'd14), 1);
    issue("R4 slt max<min",enc(7'b0000000, 5'd3, 5'd4, 3'b010, 5'd15), 1);
    issue("R4 slt -1<0",   enc(7'b0000000, 5'd1, 5'd2, 3'b010, 5'd16), 1);
    issue("R6 sll masked", enc(7'b0000000, 5'd5, 5'd6, 3'b001, 5'd17), 1);
    issue("R6 srl masked", enc(7'b0000000, 5'd5, 5'd6, 3'b101, 5'd18), 1);
    issue("R6 sra sign",   enc(7'b0100000, 5'd5, 5'd6, 3'b101, 5'd19), 1);
    issue("R6 sra by 31",  enc(7'b0100000, 5'd4, 5'd3, 3'b101, 5'd20), 1);
    issue("R5 xor",        enc(7'b0000000, 5'd6, 5'd4, 3'b100, 5'd21), 1);
    issue("R5 and",        enc(7'b0000000, 5'd6, 5'd4, 3'b111, 5'd22), 1);
    issue("R5 or",         enc(7'b0000000, 5'd6, 5'd3, 3'b110, 5'd23), 1);
    issue("R8 write x0",   enc(7'b0000000, 5'd2, 5'd6, 3'b110, 5'd0), 1);
    issue("R8 read x0",    enc(7'b0000000, 5'd0, 5'd6, 3'b000, 5'd24), 1);
    // R7 illegal encodings
    issue("R7 bad opcode", {7'b0000000, 5'd2, 5'd2, 3'b000, 5'd9, 7'b0110111}, 0);
    issue("R7 bad f7",     enc(7'b0000001, 5'd2, 5'd2, 3'b000, 5'd9), 0);
    issue("R7 bad sub f3", enc(7'b0100000, 5'd2, 5'd2, 3'b001, 5'd9), 0);

    // R10: instruction and test write on the same register in one cycle
    iw = enc(7'b0000000, 5'd6, 5'd4, 3'b000, 5'd25);
    e1 = ref_calc(7'b0, 3'b000, model[4], model[6]);
    instr_word = iw; instr_valid = 1'b1;
    tp_addr = 5'd25; tp_wdata = 32'h1234_5678; tp_we = 1'b1;
    @(posedge clk); #1;
    instr_valid = 1'b0; tp_we = 1'b0;
    @(negedge clk);
    model[25] = e1;
    tp_read_chk("R10 instruction wins", 5'd25);

    // R9: back-to-back dependent pair
    iw  = enc(7'b0000000, 5'd2, 5'd7, 3'b000, 5'd26);
    iw2 = enc(7'b0100000, 5'd26, 5'd26, 3'b001 ^ 3'b001, 5'd27);
    e1 = model[7] + model[2];
    e2 = 0;
    instr_word = iw; instr_valid = 1'b1;
    @(posedge clk); #1;
    instr_word = iw2;
    @(negedge clk);
    chk("R9 first of pair", wb_value, e1);
    model[26] = e1;
    @(posedge clk); #1;
    instr_valid = 1'b0;
    @(negedge clk);
    chk("R9 dependent second", wb_value, e2);
    chk("R9 second done", {31'b0, wb_done}, 1);
    model[27] = e2;
    @(negedge clk);
    chk("R9 done drops", {31'b0, wb_done}, 0);

    // constrained random, timing mode toggled
    for (int n = 0; n < 400; n++) begin
      int k;
      k = int'($urandom_range(9, 0));
      const_time_en = $urandom_range(1, 0);
      iw = enc(OPS[k][9:3], 5'($urandom()), 5'($urandom()), OPS[k][2:0], 5'($urandom()));
      issue("R2 random op", iw, 1);
      if (n % 50 == 0) tp_write(5'($urandom_range(31, 1)), $urandom());
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule